// File: doc/BRIEF.md
# IDE Bus-Master DMA Channel Register Block

This block holds the software-visible control and status state of a single IDE bus-master DMA channel. A host port issues byte-wide register reads and writes at eight offsets: a command byte at offset 0, a status byte at offset 2 and a little-endian 32-bit descriptor-table pointer across offsets 4 to 7. Offsets 1 and 3 are empty. The command byte drives a start level, a transfer direction and a one-cycle abort strobe toward the DMA engine.

The engine reports back with single-cycle pulses. One pulse means a descriptor was consumed, one means the transfer finished, one means an error occurred and one means the drive raised its interrupt. From these the block keeps an active flag. It also keeps two sticky flags, for error and for interrupt, which software clears by writing 1 to them. Each consumed descriptor steps the table pointer forward by one descriptor size, so a pointer read always returns the address of the next descriptor to fetch. Clearing the start bit during a transfer kills the transfer for good. To run again, software programs the channel and sets start again.

Host reads are registered: the byte appears on `host_rdata` one clock after the read request. Writes take effect at the clock edge of the request.

Top module: `ide_dma_regs`

## Requirements
- R1: After reset every register reads 00h at every offset, and `dma_start`, `dma_dir` and `dma_abort` are 0.
- R2: Offset 0 keeps only bit 3 (direction) and bit 0 (start). Bits 7:4 and 2:1 read 0. Offsets 1 and 3 read 00h and ignore writes. Read data appears on `host_rdata` one clock after the read request.
- R3: Command bit 3 drives `dma_dir` (0 = bus reads, 1 = bus writes). A write to offset 0 made while the active flag is set leaves bit 3 unchanged.
- R4: A write that takes command bit 0 from 0 to 1 sets the active flag (status bit 0) and raises `dma_start` at the same clock edge.
- R5: The active flag clears on an `eng_done` pulse, on an `eng_err` pulse, or on a write that clears command bit 0.
- R6: `dma_abort` is high for exactly one cycle after a write takes command bit 0 from 1 to 0 while the active flag is set. Clearing bit 0 while inactive gives no strobe.
- R7: Status bit 1 (error) is set by `eng_err` and stays set until software writes 1 to bit 1 at offset 2. Writing 0 there has no effect.
- R8: Status bit 2 (interrupt) is set by `eng_irq` and clears only when software writes 1 to bit 2 at offset 2.
- R9: When a set pulse and a write-1-to-clear hit the same flag in the same cycle, the flag ends up set.
- R10: Status bits 6 and 5 (drive 1 and drive 0 DMA-capable) are read/write. Bits 7, 4 and 3 read 0, and bit 0 ignores writes.
- R11: Offsets 4 to 7 hold pointer bits 7:0, 15:8, 23:16 and 31:24 in that order. Pointer bits 1:0 always read 0.
- R12: Each `eng_adv` pulse while the active flag is set adds 8 to the pointer (modulo 2^32), unless that cycle also writes a pointer byte. An `eng_adv` pulse while inactive leaves the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel | input | 1 | Register access request this cycle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 3 | Byte offset |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, valid one clock after the request |
| eng_adv | input | 1 | Descriptor consumed pulse |
| eng_done | input | 1 | Transfer finished pulse |
| eng_err | input | 1 | Transfer error pulse |
| eng_irq | input | 1 | Drive interrupt pulse |
| dma_start | output | 1 | Command start bit level |
| dma_dir | output | 1 | Transfer direction, 1 = bus writes |
| dma_abort | output | 1 | One-cycle abort strobe |
| dma_tbl_ptr | output | 32 | Next descriptor address |

## Verification
A wrong active flag shows at status bit 0 on the next read. The same fault also shows at the next edge on `dma_abort`, which fails to fire or fires when it should not, and on `dma_dir`, which moves when it should be locked. A lost or wrongly cleared sticky flag shows at status bits 1 and 2 on the first read after the event or the clearing write. A pointer stepping fault shows on `dma_tbl_ptr` one clock after the `eng_adv` pulse, and through the four pointer bytes on readback.

// File: rtl/ide_dma_pkg.sv
package ide_dma_pkg;
  localparam int unsigned OFF_CMD   = 0;
  localparam int unsigned OFF_STAT  = 2;
  localparam int unsigned OFF_PTR   = 4;
  localparam int unsigned CMD_START = 0;
  localparam int unsigned CMD_DIR   = 3;
  localparam int unsigned ST_ACT    = 0;
  localparam int unsigned ST_ERR    = 1;
  localparam int unsigned ST_IRQ    = 2;
  localparam int unsigned ST_CAP0   = 5;
  localparam int unsigned ST_CAP1   = 6;
  localparam int unsigned NFLAGS    = 2;

  typedef struct packed {
    logic       start;
    logic       dir;
    logic       active;
    logic       abort;
  } cmd_state_t;
endpackage

// File: rtl/ide_sticky_bit.sv
module ide_sticky_bit (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  // set has priority over a software clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= set_i | (q & ~clr_i);
  end
endmodule

// File: rtl/ide_cmd_ctl.sv
module ide_cmd_ctl
  import ide_dma_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_cmd,
  input  logic [7:0] wdata,
  input  logic       done_i,
  input  logic       err_i,
  output cmd_state_t st
);
  logic start_rise, start_fall;

  assign start_rise = wr_cmd &  wdata[CMD_START] & ~st.start;
  assign start_fall = wr_cmd & ~wdata[CMD_START] &  st.start;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= '0;
    end else begin
      if (wr_cmd) st.start <= wdata[CMD_START];
      if (wr_cmd && !st.active) st.dir <= wdata[CMD_DIR];
      if (start_rise)                           st.active <= 1'b1;
      else if (start_fall || done_i || err_i)   st.active <= 1'b0;
      st.abort <= start_fall & st.active;
    end
  end
endmodule

// File: rtl/ide_status.sv
module ide_status
  import ide_dma_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_stat,
  input  logic [7:0] wdata,
  input  logic       err_evt,
  input  logic       irq_evt,
  output logic       err_q,
  output logic       irq_q,
  output logic [1:0] cap_q
);
  logic [NFLAGS-1:0] set_v, clr_v, q_v;

  assign set_v = {irq_evt, err_evt};
  assign clr_v = {wr_stat & wdata[ST_IRQ], wr_stat & wdata[ST_ERR]};

  genvar i;
  generate
    for (i = 0; i < NFLAGS; i++) begin : g_flag
      ide_sticky_bit u_bit (
        .clk   (clk),
        .rst   (rst),
        .set_i (set_v[i]),
        .clr_i (clr_v[i]),
        .q     (q_v[i])
      );
    end
  endgenerate

  assign err_q = q_v[0];
  assign irq_q = q_v[1];

  always_ff @(posedge clk) begin
    if (rst)          cap_q <= 2'b00;
    else if (wr_stat) cap_q <= {wdata[ST_CAP1], wdata[ST_CAP0]};
  end
endmodule

// File: rtl/ide_desc_ptr.sv
module ide_desc_ptr #(
  parameter int unsigned PTR_W  = 32,
  parameter int unsigned STRIDE = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [$clog2(PTR_W/8)-1:0]    lane,
  input  logic [7:0]                    wdata,
  input  logic                          adv,
  output logic [PTR_W-1:0]              ptr_q
);
  localparam int unsigned NBYTES = PTR_W / 8;

  logic [PTR_W-1:0] nxt;

  genvar b;
  generate
    for (b = 0; b < NBYTES; b++) begin : g_lane
      always_comb begin
        if (wr_en && lane == b[$clog2(PTR_W/8)-1:0])
          nxt[b*8 +: 8] = wdata;
        else if (!wr_en && adv)
          nxt[b*8 +: 8] = (ptr_q + PTR_W'(STRIDE)) >> (b*8);
        else
          nxt[b*8 +: 8] = ptr_q[b*8 +: 8];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) ptr_q <= '0;
    else     ptr_q <= {nxt[PTR_W-1:2], 2'b00};
  end
endmodule

// File: rtl/ide_dma_regs.sv
module ide_dma_regs
  import ide_dma_pkg::*;
#(
  parameter int unsigned PTR_W  = 32,
  parameter int unsigned STRIDE = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_sel,
  input  logic             host_we,
  input  logic [2:0]       host_addr,
  input  logic [7:0]       host_wdata,
  output logic [7:0]       host_rdata,
  input  logic             eng_adv,
  input  logic             eng_done,
  input  logic             eng_err,
  input  logic             eng_irq,
  output logic             dma_start,
  output logic             dma_dir,
  output logic             dma_abort,
  output logic [PTR_W-1:0] dma_tbl_ptr
);
  localparam int unsigned LANE_W = $clog2(PTR_W / 8);

  logic       wr, rd, wr_cmd, wr_stat, wr_ptr;
  cmd_state_t cst;
  logic       act_q, err_q, irq_q;
  logic [1:0] cap_q;
  logic [7:0] rnext;

  assign wr      = host_sel &  host_we;
  assign rd      = host_sel & ~host_we;
  assign wr_cmd  = wr && host_addr == 3'(OFF_CMD);
  assign wr_stat = wr && host_addr == 3'(OFF_STAT);
  assign wr_ptr  = wr && host_addr >= 3'(OFF_PTR);

  ide_cmd_ctl u_cmd (
    .clk    (clk),
    .rst    (rst),
    .wr_cmd (wr_cmd),
    .wdata  (host_wdata),
    .done_i (eng_done),
    .err_i  (eng_err),
    .st     (cst)
  );

  assign act_q     = cst.active;
  assign dma_start = cst.start;
  assign dma_dir   = cst.dir;
  assign dma_abort = cst.abort;

  ide_status u_stat (
    .clk     (clk),
    .rst     (rst),
    .wr_stat (wr_stat),
    .wdata   (host_wdata),
    .err_evt (eng_err),
    .irq_evt (eng_irq),
    .err_q   (err_q),
    .irq_q   (irq_q),
    .cap_q   (cap_q)
  );

  ide_desc_ptr #(.PTR_W(PTR_W), .STRIDE(STRIDE)) u_ptr (
    .clk   (clk),
    .rst   (rst),
    .wr_en (wr_ptr),
    .lane  (host_addr[LANE_W-1:0]),
    .wdata (host_wdata),
    .adv   (eng_adv & act_q),
    .ptr_q (dma_tbl_ptr)
  );

  always_comb begin
    rnext = 8'h00;
    if (host_addr >= 3'(OFF_PTR)) begin
      rnext = dma_tbl_ptr[host_addr[LANE_W-1:0]*8 +: 8];
    end else if (host_addr == 3'(OFF_CMD)) begin
      rnext[CMD_START] = cst.start;
      rnext[CMD_DIR]   = cst.dir;
    end else if (host_addr == 3'(OFF_STAT)) begin
      rnext[ST_ACT]  = act_q;
      rnext[ST_ERR]  = err_q;
      rnext[ST_IRQ]  = irq_q;
      rnext[ST_CAP0] = cap_q[0];
      rnext[ST_CAP1] = cap_q[1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     host_rdata <= 8'h00;
    else if (rd) host_rdata <= rnext;
  end
endmodule

// File: rtl/ide_dma_regs_chk.sv
module ide_dma_regs_chk #(
  parameter int unsigned PTR_W  = 32,
  parameter int unsigned STRIDE = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             host_sel,
  input logic             host_we,
  input logic [2:0]       host_addr,
  input logic [7:0]       host_wdata,
  input logic             eng_adv,
  input logic             eng_done,
  input logic             eng_err,
  input logic             eng_irq,
  input logic             dma_start,
  input logic             dma_dir,
  input logic             dma_abort,
  input logic [PTR_W-1:0] dma_tbl_ptr,
  input logic             act_q,
  input logic             err_q,
  input logic             irq_q
);
  logic cmd_wr, err_clr, ptr_wr;
  assign cmd_wr  = host_sel && host_we && host_addr == 3'd0;
  assign err_clr = host_sel && host_we && host_addr == 3'd2 && host_wdata[1];
  assign ptr_wr  = host_sel && host_we && host_addr >= 3'd4;

  a_r6_abort_single: assert property (@(posedge clk) disable iff (rst)
    dma_abort |=> !dma_abort);

  a_r6_abort_stopped: assert property (@(posedge clk) disable iff (rst)
    dma_abort |-> (!act_q && !dma_start));

  a_r4_start_sets_active: assert property (@(posedge clk) disable iff (rst)
    $rose(dma_start) |-> act_q);

  a_r3_dir_locked: assert property (@(posedge clk) disable iff (rst)
    act_q |=> $stable(dma_dir));

  a_r5_done_clears: assert property (@(posedge clk) disable iff (rst)
    (eng_done && !cmd_wr) |=> !act_q);

  a_r7_err_sticky: assert property (@(posedge clk) disable iff (rst)
    (err_q && !err_clr) |=> err_q);

  a_r9_err_set_wins: assert property (@(posedge clk) disable iff (rst)
    eng_err |=> err_q);

  a_r9_irq_set_wins: assert property (@(posedge clk) disable iff (rst)
    eng_irq |=> irq_q);

  a_r12_ptr_step: assert property (@(posedge clk) disable iff (rst)
    (eng_adv && act_q && !ptr_wr) |=> dma_tbl_ptr == $past(dma_tbl_ptr) + PTR_W'(STRIDE));

  a_r12_ptr_idle: assert property (@(posedge clk) disable iff (rst)
    (!act_q && !ptr_wr) |=> $stable(dma_tbl_ptr));
endmodule

bind ide_dma_regs ide_dma_regs_chk #(.PTR_W(PTR_W), .STRIDE(STRIDE)) u_chk (
  .clk(clk), .rst(rst), .host_sel(host_sel), .host_we(host_we),
  .host_addr(host_addr), .host_wdata(host_wdata), .eng_adv(eng_adv),
  .eng_done(eng_done), .eng_err(eng_err), .eng_irq(eng_irq),
  .dma_start(dma_start), .dma_dir(dma_dir), .dma_abort(dma_abort),
  .dma_tbl_ptr(dma_tbl_ptr), .act_q(act_q), .err_q(err_q), .irq_q(irq_q)
);

// File: tb/ide_dma_regs_test.sv
module ide_dma_regs_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_sel = 1'b0, host_we = 1'b0;
  logic [2:0]  host_addr = 3'd0;
  logic [7:0]  host_wdata = 8'h00;
  logic [7:0]  host_rdata;
  logic        eng_adv = 1'b0, eng_done = 1'b0, eng_err = 1'b0, eng_irq = 1'b0;
  logic        dma_start, dma_dir, dma_abort;
  logic [31:0] dma_tbl_ptr;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  ide_dma_regs uut (
    .clk(clk), .rst(rst), .host_sel(host_sel), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .eng_adv(eng_adv), .eng_done(eng_done), .eng_err(eng_err), .eng_irq(eng_irq),
    .dma_start(dma_start), .dma_dir(dma_dir), .dma_abort(dma_abort),
    .dma_tbl_ptr(dma_tbl_ptr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    host_sel = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_sel = 1'b0; host_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    host_sel = 1'b1; host_we = 1'b0; host_addr = a;
    @(negedge clk);
    host_sel = 1'b0;
    d = host_rdata;
  endtask

  task automatic rd_ptr(output logic [31:0] p);
    logic [7:0] b;
    for (int k = 0; k < 4; k++) begin
      rd(3'(4 + k), b);
      p[k*8 +: 8] = b;
    end
  endtask

  task automatic adv_pulse;
    @(negedge clk); eng_adv = 1'b1;
    @(negedge clk); eng_adv = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0]  r;
    logic [31:0] p;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), r);
      chk("R1 reset read", {24'd0, r}, 32'h0);
    end
    chk("R1 reset outputs", {29'd0, dma_start, dma_dir, dma_abort}, 32'h0);

    // R2/R3/R4 command sweep, starting each value from an idle channel
    for (int v = 0; v < 256; v++) begin
      wr(3'd0, 8'h00);
      wr(3'd0, 8'(v));
      rd(3'd0, r);
      chk("R2 command readback", {24'd0, r}, {24'd0, 8'(v) & 8'h09});
      chk("R3 dir output", {31'd0, dma_dir}, {31'd0, 1'(v >> 3)});
      chk("R4 start output", {31'd0, dma_start}, {31'd0, 1'(v)});
      rd(3'd2, r);
      chk("R4 active flag", {24'd0, r}, {24'd0, 7'd0, 1'(v)});
    end
    wr(3'd0, 8'h00);

    // R2 empty offsets
    wr(3'd1, 8'hFF); wr(3'd3, 8'hFF);
    rd(3'd1, r); chk("R2 offset 1", {24'd0, r}, 32'h0);
    rd(3'd3, r); chk("R2 offset 3", {24'd0, r}, 32'h0);

    // R10 status sweep (flags clear, channel idle)
    for (int v = 0; v < 256; v++) begin
      wr(3'd2, 8'(v));
      rd(3'd2, r);
      chk("R10 status readback", {24'd0, r}, {24'd0, 8'(v) & 8'h60});
    end
    wr(3'd2, 8'h00);

    // R11 pointer byte sweep
    for (int off = 4; off < 8; off++) begin
      for (int v = 0; v < 256; v++) begin
        wr(3'(off), 8'(v));
        rd(3'(off), r);
        chk("R11 pointer byte", {24'd0, r}, {24'd0, (off == 4) ? (8'(v) & 8'hFC) : 8'(v)});
      end
    end
    wr(3'd4, 8'h78); wr(3'd5, 8'h56); wr(3'd6, 8'h34); wr(3'd7, 8'h12);
    chk("R11 byte order", dma_tbl_ptr, 32'h12345678);

    // R12 advance with wrap
    wr(3'd4, 8'hF0); wr(3'd5, 8'hFF); wr(3'd6, 8'hFF); wr(3'd7, 8'hFF);
    wr(3'd0, 8'h01);
    for (int k = 1; k <= 3; k++) begin
      adv_pulse();
      chk("R12 advance", dma_tbl_ptr, 32'hFFFFFFF0 + 32'(8 * k));
    end
    rd_ptr(p);
    chk("R12 readback next descriptor", p, 32'h00000008);

    // R3 dir locked while active
    wr(3'd0, 8'h09);
    rd(3'd0, r);
    chk("R3 dir locked", {24'd0, r}, 32'h01);
    chk("R3 dir pin", {31'd0, dma_dir}, 32'h0);

    // R6 abort strobe
    wr(3'd0, 8'h00);
    chk("R6 abort high", {31'd0, dma_abort}, 32'h1);
    @(negedge clk);
    chk("R6 abort one cycle", {31'd0, dma_abort}, 32'h0);
    rd(3'd2, r);
    chk("R5 cleared by stop", {24'd0, r}, 32'h0);
    adv_pulse();
    chk("R12 idle advance ignored", dma_tbl_ptr, 32'h00000008);
    wr(3'd0, 8'h00);
    chk("R6 no abort when idle", {31'd0, dma_abort}, 32'h0);

    // R5 done clears active, start stays
    wr(3'd0, 8'h01);
    @(negedge clk); eng_done = 1'b1;
    @(negedge clk); eng_done = 1'b0;
    rd(3'd2, r);
    chk("R5 done clears active", {24'd0, r}, 32'h0);
    chk("R5 start still set", {31'd0, dma_start}, 32'h1);
    wr(3'd0, 8'h00);
    chk("R6 no abort after done", {31'd0, dma_abort}, 32'h0);

    // R5/R7 error pulse
    wr(3'd0, 8'h01);
    @(negedge clk); eng_err = 1'b1;
    @(negedge clk); eng_err = 1'b0;
    rd(3'd2, r);
    chk("R7 error set, R5 active cleared", {24'd0, r}, 32'h02);
    wr(3'd0, 8'h00);
    wr(3'd2, 8'h00);
    rd(3'd2, r);
    chk("R7 write 0 keeps error", {24'd0, r}, 32'h02);
    wr(3'd2, 8'h02);
    rd(3'd2, r);
    chk("R7 write 1 clears error", {24'd0, r}, 32'h0);

    // R8 interrupt flag
    @(negedge clk); eng_irq = 1'b1;
    @(negedge clk); eng_irq = 1'b0;
    rd(3'd2, r);
    chk("R8 interrupt set", {24'd0, r}, 32'h04);
    wr(3'd2, 8'h02);
    rd(3'd2, r);
    chk("R8 other clear keeps irq", {24'd0, r}, 32'h04);
    wr(3'd2, 8'h04);
    rd(3'd2, r);
    chk("R8 interrupt cleared", {24'd0, r}, 32'h0);

    // R9 set beats clear in the same cycle
    @(negedge clk);
    host_sel = 1'b1; host_we = 1'b1; host_addr = 3'd2; host_wdata = 8'h06;
    eng_err = 1'b1; eng_irq = 1'b1;
    @(negedge clk);
    host_sel = 1'b0; host_we = 1'b0; eng_err = 1'b0; eng_irq = 1'b0;
    rd(3'd2, r);
    chk("R9 set wins", {24'd0, r}, 32'h06);
    wr(3'd2, 8'h06);
    rd(3'd2, r);
    chk("R9 later clear", {24'd0, r}, 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule